// File: doc/BRIEF.md
# Interrupt notification message generator

This block sits behind a small bank of interrupt sources and converts each source event into one 64-bit memory write that announces the interrupt to a remote controller. Two configuration words come from an external register file. The first is the notification port: its least significant bit says whether notifications are enabled, and the remaining bits give the target byte address. The second is the vector-table offset, whose upper half is the base number that is added to the source index to form the logical interrupt number.

Each event carries a source index. Valid indices are recorded in a pending mask. The block drains this mask lowest index first, one write per recorded event, on a valid/ready write request port. The address and the payload are taken from the configuration words in the cycle the write is issued. The payload goes out in big-endian byte order. An event with an index outside the source range is dropped and raises an error flag for one cycle.

Top module: `nmg_notify_gen`

## Requirements
- R1: An issued write carries wr_addr equal to port_reg with bit 0 forced to 0, and a write is issued only when port_reg bit 0 is 1 at issue time.
- R2: When port_reg bit 0 is 0 at the moment a pending event would be issued, that event is discarded and no write appears on the port.
- R3: The payload value is ivt_reg[63:32], zero-extended to 64 bits, plus the source index, computed in 64 bits so that a carry reaches bit 32.
- R4: The payload is presented big-endian: wr_data[7:0] holds value bits 63:56, and so on up to wr_data[63:56], which holds value bits 7:0.
- R5: Once wr_valid is high it stays high, with wr_addr and wr_data unchanged, until a cycle in which wr_ready is high.
- R6: Events that arrive while a write is stalled wait in a 14-bit pending mask and are issued lowest index first. A second event for a source that is already pending merges with the first and yields one write.
- R7: port_reg and ivt_reg are sampled when a write is issued. A change made while a write is stalled does not alter that write but applies to every later one.
- R8: An event with evt_src of 14 or more produces no write and raises err_flag for exactly the one cycle after the event.
- R9: After reset, wr_valid and err_flag are 0 and no event is pending.
- R10: With the output idle and the port enabled, wr_valid rises after the second rising clock edge following the event cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_reg | input | 64 | Notification port: bit 0 enable, other bits the address |
| ivt_reg | input | 64 | Vector-table offset; bits 63:32 are the base number |
| evt_valid | input | 1 | Source event strobe, one cycle per event |
| evt_src | input | 4 | Index of the source that fired |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted when high together with wr_valid |
| wr_addr | output | 64 | Write byte address, bit 0 always 0 |
| wr_data | output | 64 | Big-endian payload |
| err_flag | output | 1 | One-cycle flag for an out-of-range source index |

## Verification
A corrupt pending mask shows up at the ports as a missing, duplicated or reordered write once the stalled write is released, so the bench stalls the port, queues several sources and then checks the exact order of the writes that follow. A wrong formatter or a wrong sampling point shows up in the address or data of the first write after a register change, and a wrong enable or range check shows up as a write that should not appear in the next few cycles. The bench compares every issued write against a reference that it computes itself.

// File: rtl/nmg_pkg.sv
// Package: shared sizes and helpers for the notification message generator.
// Assumes 64-bit address and data words and a byte-addressed target.
package nmg_pkg;
    localparam int unsigned WORD_W   = 64;
    localparam int unsigned BYTES    = WORD_W / 8;
    localparam int unsigned OFF_LSB  = 32;
    localparam int unsigned OFF_W    = WORD_W - OFF_LSB;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/nmg_pending.sv
// Module: nmg_pending
// Holds one bit per source that has fired and has not yet been issued.
// Assumes set and clear vectors arrive in the same cycle. A set takes
// precedence over a clear of the same bit, so a new event is never lost.
module nmg_pending #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] pend
);
    // Update the mask: drop issued bits, then add new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    // R6
    clear_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & ~pend) == '0);
endmodule

// File: rtl/nmg_pick.sv
// Module: nmg_pick
// Selects the lowest-numbered pending source. Purely combinational.
// Assumes the caller qualifies the grant with any_pend.
module nmg_pick #(
    parameter int unsigned NUM_SRC = 14,
    localparam int unsigned SRC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any_pend,
    output logic [SRC_W-1:0]   pick_idx,
    output logic [NUM_SRC-1:0] pick_vec
);
    // Scan from the top down so that the lowest set bit is the one that remains.
    always_comb begin
        pick_idx = '0;
        pick_vec = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                pick_idx = SRC_W'(i);
                pick_vec = NUM_SRC'(1) << i;
            end
        end
        any_pend = |pend;
    end
endmodule

// File: rtl/nmg_format.sv
// Module: nmg_format
// Builds the write address and the big-endian payload from the two
// configuration words and a source index. Combinational.
// Assumes ivt_reg bits below OFF_LSB carry no meaning.
module nmg_format
    import nmg_pkg::*;
#(
    parameter int unsigned SRC_W = 4
) (
    input  word_t             port_reg,
    input  word_t             ivt_reg,
    input  logic [SRC_W-1:0]  src_idx,
    output word_t             addr,
    output word_t             data
);
    word_t value;
    logic  unused_ivt_lo;

    assign unused_ivt_lo = ^ivt_reg[OFF_LSB-1:0];

    // Target address: the enable bit is masked off.
    assign addr = {port_reg[WORD_W-1:1], 1'b0};

    // Logical interrupt number: base from the upper half plus the index.
    assign value = word_t'(ivt_reg[WORD_W-1:OFF_LSB]) + word_t'(src_idx);

    // Byte reversal so that the most significant byte goes out first.
    for (genvar b = 0; b < BYTES; b++) begin : g_swap
        assign data[8*b +: 8] = value[8*(BYTES-1-b) +: 8];
    end
endmodule

// File: rtl/nmg_notify_gen.sv
// Module: nmg_notify_gen (top)
// Turns source events into 64-bit notification writes on a valid/ready port.
// Assumes at most one event per cycle and configuration words that come
// from a register file clocked by clk. The words are sampled at issue.
module nmg_notify_gen
    import nmg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 14,
    localparam int unsigned SRC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      port_reg,
    input  logic [63:0]      ivt_reg,
    input  logic             evt_valid,
    input  logic [SRC_W-1:0] evt_src,
    output logic             wr_valid,
    input  logic             wr_ready,
    output logic [63:0]      wr_addr,
    output logic [63:0]      wr_data,
    output logic             err_flag
);
    logic [NUM_SRC-1:0] set_vec, clr_vec, pend, pick_vec;
    logic               any_pend, load, issue, evt_bad;
    logic [SRC_W-1:0]   pick_idx;
    word_t              fmt_addr, fmt_data;

    // Decode the incoming event into a one-hot set vector when in range.
    always_comb begin
        evt_bad = evt_valid && (evt_src >= SRC_W'(NUM_SRC));
        set_vec = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (evt_valid && evt_src == SRC_W'(i)) set_vec[i] = 1'b1;
    end

    nmg_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
    );

    nmg_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend(pend), .any_pend(any_pend), .pick_idx(pick_idx), .pick_vec(pick_vec)
    );

    nmg_format #(.SRC_W(SRC_W)) u_fmt (
        .port_reg(port_reg), .ivt_reg(ivt_reg), .src_idx(pick_idx),
        .addr(fmt_addr), .data(fmt_data)
    );

    // Issue decision: take the next pending source when the output is free.
    assign load    = any_pend && (!wr_valid || wr_ready);
    assign issue   = load && port_reg[0];
    assign clr_vec = load ? pick_vec : '0;

    // Output request register, held until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (load) begin
            wr_valid <= issue;
            if (issue) begin
                wr_addr <= fmt_addr;
                wr_data <= fmt_data;
            end
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // One-cycle error flag for an out-of-range source index.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= evt_bad;
    end

    // R5
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R1
    addr_bit0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[0] == 1'b0));

    // R2
    enabled_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(port_reg[0]));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> $past(evt_valid && (evt_src >= SRC_W'(NUM_SRC))));
endmodule

// File: tb/tb_nmg_notify_gen.sv
module tb_nmg_notify_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] port_reg = '0, ivt_reg = '0;
    logic        evt_valid = 1'b0;
    logic [3:0]  evt_src = '0;
    logic        wr_valid, wr_ready = 1'b1, err_flag;
    logic [63:0] wr_addr, wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    nmg_notify_gen dut (
        .clk(clk), .rst_n(rst_n), .port_reg(port_reg), .ivt_reg(ivt_reg),
        .evt_valid(evt_valid), .evt_src(evt_src), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [63:0] port;
        logic [63:0] ivt;
        logic [3:0]  src;
        logic [63:0] value;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{64'h0000_0006_0302_0001, 64'h0000_1000_0000_0000, 4'd3,  64'h0000_0000_0000_1003},
        '{64'h0000_0000_0000_8001, 64'h0000_0000_FFFF_FFFF, 4'd0,  64'h0000_0000_0000_0000},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 4'd13, 64'h0000_0001_0000_000C},
        '{64'h1234_5678_9ABC_DEF1, 64'h0102_0304_0000_0000, 4'd7,  64'h0000_0000_0102_030B}
    };

    function automatic logic [63:0] swap8(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] ref_data(input logic [63:0] ivt, input int src);
        return swap8({32'h0, ivt[63:32]} + 64'(src));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] s);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_src   = s;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    // Wait for an accepted write and compare it; ends just after the accepting edge.
    task automatic expect_write(input logic [63:0] ea, input logic [63:0] ed, input string tag);
        bit seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (wr_valid && wr_ready) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(seen, {tag, " write seen"}, 64'(seen), 64'd1);
        if (seen) begin
            chk(wr_addr == ea, {tag, " addr"}, wr_addr, ea);
            chk(wr_data == ed, {tag, " data"}, wr_data, ed);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        bit any = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (wr_valid) any = 1;
        end
        chk(!any, tag, 64'(any), 64'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] ivt_old, ivt_new, prt;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(wr_valid == 1'b0, "R9 wr_valid in reset", 64'(wr_valid), 64'd0);
        chk(err_flag == 1'b0, "R9 err_flag in reset", 64'(err_flag), 64'd0);
        rst_n = 1'b1;
        expect_quiet(3, "R9 no write after reset");

        // R1 R3 R4 R10: table of vectors, output idle, ready high
        foreach (VECS[i]) begin
            port_reg = VECS[i].port;
            ivt_reg  = VECS[i].ivt;
            @(negedge clk);
            evt_valid = 1'b1;
            evt_src   = VECS[i].src;
            @(negedge clk);
            evt_valid = 1'b0;
            chk(wr_valid == 1'b0, "R10 not before second edge", 64'(wr_valid), 64'd0);
            @(negedge clk);
            chk(wr_valid == 1'b1, "R10 valid after second edge", 64'(wr_valid), 64'd1);
            chk(wr_addr == {VECS[i].port[63:1], 1'b0}, "R1 address", wr_addr, {VECS[i].port[63:1], 1'b0});
            chk(wr_data == swap8(VECS[i].value), "R3 R4 payload", wr_data, swap8(VECS[i].value));
            chk(wr_data == ref_data(VECS[i].ivt, int'(VECS[i].src)), "R3 computed payload", wr_data,
                ref_data(VECS[i].ivt, int'(VECS[i].src)));
            @(posedge clk);
            @(negedge clk);
            chk(wr_valid == 1'b0, "R5 drops after accept", 64'(wr_valid), 64'd0);
        end

        // R2: disabled port, no write
        port_reg = 64'h0000_0000_0000_4000;
        pulse(4'd2);
        expect_quiet(6, "R2 no write while disabled");
        port_reg = 64'h0000_0000_0000_4001;
        expect_quiet(4, "R2 discarded event stays gone");

        // R8: out-of-range index
        @(negedge clk);
        evt_valid = 1'b1;
        evt_src   = 4'd14;
        @(negedge clk);
        evt_valid = 1'b0;
        chk(err_flag == 1'b1, "R8 err raised", 64'(err_flag), 64'd1);
        @(negedge clk);
        chk(err_flag == 1'b0, "R8 err one cycle", 64'(err_flag), 64'd0);
        pulse(4'd15);
        expect_quiet(5, "R8 no write for bad index");

        // R5 R6 R7: stall, queue, merge, change register
        prt     = 64'h0000_00AB_CDEF_0101;
        ivt_old = 64'h0000_0200_0000_0000;
        ivt_new = 64'h0000_0900_0000_0000;
        port_reg = prt;
        ivt_reg  = ivt_old;
        @(negedge clk);
        wr_ready = 1'b0;
        pulse(4'd9);
        evt_valid = 1'b1; evt_src = 4'd3; @(negedge clk);
        evt_src = 4'd7; @(negedge clk);
        evt_src = 4'd5; @(negedge clk);
        evt_src = 4'd5; @(negedge clk);
        evt_valid = 1'b0;
        ivt_reg = ivt_new;
        @(negedge clk);
        @(negedge clk);
        chk(wr_valid == 1'b1, "R5 held while stalled", 64'(wr_valid), 64'd1);
        chk(wr_data == ref_data(ivt_old, 9), "R7 stalled write unchanged", wr_data, ref_data(ivt_old, 9));
        wr_ready = 1'b1;
        expect_write({prt[63:1], 1'b0}, ref_data(ivt_old, 9), "R6 first src9");
        expect_write({prt[63:1], 1'b0}, ref_data(ivt_new, 3), "R6 R7 src3 new offset");
        expect_write({prt[63:1], 1'b0}, ref_data(ivt_new, 5), "R6 src5 merged");
        expect_write({prt[63:1], 1'b0}, ref_data(ivt_new, 7), "R6 src7");
        expect_quiet(5, "R6 no extra write after merge");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule